// File: doc/BRIEF.md
# Half-Duplex UART Bus Collision Detector

When a UART's transmit and receive pins are tied to one shared wire, every bit the transmitter drives should come straight back on the receive line. This block watches that echo. It compares the synchronized receive level against the transmit level that was being driven, and raises a sticky collision flag with a one-cycle interrupt pulse when the two differ. The comparison happens only at a sampling strobe. That strobe is either the rising edge of the shifter's transfer clock or an underflow pulse from an external timer, chosen by a select input. Comparisons are made only while a frame is being transmitted.

The block also owns the transmit-enable bit. If automatic clearing is on, a collision drops transmit-enable in the same cycle that the flag is set. A transmit request can start the shifter on the next cycle. It can instead be held pending until the synchronized receive line shows a rising edge, so that transmission lines up with activity on the shared wire. The shifter and the timer are outside the block, and their strobes arrive as inputs.

Top module: `uart_bus_collision_det`

## Requirements
- R1: After reset, tx_en, tx_start, coll_flag and coll_irq are all 0.
- R2: At a selected sampling strobe during a frame, coll_flag is set when the synchronized receive level differs from the transmit level delayed by the same two cycles. It is not set when the two levels match.
- R3: With smp_sel = 0, the strobe is a 0-to-1 transition of xfer_clk. Pulses on tmr_uflow cause no comparison.
- R4: With smp_sel = 1, the strobe is a high cycle of tmr_uflow. Rising edges of xfer_clk cause no comparison.
- R5: A mismatch sampled while frame_act (delayed with the data) is 0 does not set coll_flag.
- R6: coll_flag stays 1 until irq_clr is asserted. A collision in the same cycle as irq_clr keeps the flag at 1.
- R7: coll_irq pulses for one cycle, in the cycle coll_flag goes from 0 to 1, and not for later collisions while the flag is already 1.
- R8: With auto_clr_en = 1, a collision clears tx_en on the same clock edge that sets coll_flag. With auto_clr_en = 0, tx_en is left unchanged.
- R9: With start_sync_en = 0 and tx_en = 1, a tx_req cycle produces a one-cycle tx_start on the following cycle.
- R10: With start_sync_en = 1, a request is held pending, and tx_start pulses once only after a rising edge of the synchronized receive line.
- R11: tx_req is ignored while tx_en is 0.
- R12: Dropping tx_en cancels a pending synchronized start, so a later receive rising edge gives no tx_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rxd_pin | input | 1 | Receive pin level (asynchronous) |
| txd_lvl | input | 1 | Level currently driven on the transmit pin |
| frame_act | input | 1 | High while the shifter transmits a frame |
| xfer_clk | input | 1 | Transfer clock level from the shifter |
| tmr_uflow | input | 1 | Timer underflow pulse |
| smp_sel | input | 1 | Strobe source: 0 transfer clock rise, 1 timer underflow |
| auto_clr_en | input | 1 | Clear tx_en on collision |
| start_sync_en | input | 1 | Start only after a receive rising edge |
| tx_en_set | input | 1 | Set transmit-enable |
| tx_en_clr | input | 1 | Clear transmit-enable |
| tx_req | input | 1 | Transmit request |
| irq_clr | input | 1 | Clear the collision flag |
| tx_en | output | 1 | Transmit-enable bit |
| tx_start | output | 1 | One-cycle start strobe to the shifter |
| coll_flag | output | 1 | Sticky collision flag |
| coll_irq | output | 1 | One-cycle collision interrupt pulse |

## Verification
Several properties are checked by assertions on every cycle:
- a collision sets the flag on the next edge;
- the flag holds until it is cleared;
- the interrupt only accompanies a rise of the flag;
- auto-clear removes transmit-enable;
- an unsynchronized request starts next cycle;
- a pending request never starts without a receive rising edge.

Other behaviours can only be shown by the bench's scenarios. These are that the unselected strobe source and idle periods really are ignored, that the delayed comparison lines up with the levels the bench drove, that a set collides correctly with a clear, and that a cancelled pending request stays dead.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic {
    SRC_XFER  = 1'b0,
    SRC_TIMER = 1'b1
  } smp_src_e;
endpackage

// File: rtl/bcd_line_sync.sv
module bcd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_pin,
  input  logic txd_lvl,
  input  logic frame_act,
  output logic rxd_s,
  output logic rxd_rise,
  output logic txd_d,
  output logic act_d
);
  logic [STAGES-1:0] rx_q, rx_d, tx_q, tx_d, ac_q, ac_d;
  logic rx_last_q, rx_last_d;

  always_comb begin
    rx_d      = STAGES'({rx_q, rxd_pin});
    tx_d      = STAGES'({tx_q, txd_lvl});
    ac_d      = STAGES'({ac_q, frame_act});
    rx_last_d = rx_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      tx_q      <= '0;
      ac_q      <= '0;
      rx_last_q <= 1'b0;
    end else begin
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      ac_q      <= ac_d;
      rx_last_q <= rx_last_d;
    end
  end

  assign rxd_s    = rx_q[STAGES-1];
  assign txd_d    = tx_q[STAGES-1];
  assign act_d    = ac_q[STAGES-1];
  assign rxd_rise = rx_q[STAGES-1] & ~rx_last_q;
endmodule

// File: rtl/bcd_strobe_sel.sv
module bcd_strobe_sel
  import bcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_clk,
  input  logic tmr_uflow,
  input  logic smp_sel,
  output logic strobe
);
  logic     xclk_q, xclk_d, xrise;
  smp_src_e src;

  always_comb begin
    xclk_d = xfer_clk;
    xrise  = xfer_clk & ~xclk_q;
    src    = smp_src_e'(smp_sel);
    strobe = (src == SRC_TIMER) ? tmr_uflow : xrise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xclk_q <= 1'b0;
    else        xclk_q <= xclk_d;
  end
endmodule

// File: rtl/bcd_coll_flag.sv
module bcd_coll_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic act_d,
  input  logic rxd_s,
  input  logic txd_d,
  input  logic irq_clr,
  output logic hit,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    hit    = strobe & act_d & (rxd_s ^ txd_d);
    flag_d = hit | (flag_q & ~irq_clr);
    irq_d  = hit & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R2
  coll_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !irq_clr |=> flag_q);
  // R7
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $rose(flag_q));
endmodule

// File: rtl/bcd_tx_gate.sv
module bcd_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic auto_clr_en,
  input  logic tx_en_set,
  input  logic tx_en_clr,
  input  logic tx_req,
  input  logic start_sync_en,
  input  logic rx_rise,
  output logic tx_en,
  output logic tx_start
);
  logic en_q, en_d, pend_q, pend_d, start_q, start_d;

  always_comb begin
    en_d = en_q;
    if (tx_en_set)         en_d = 1'b1;
    if (tx_en_clr)         en_d = 1'b0;
    if (hit && auto_clr_en) en_d = 1'b0;

    pend_d = pend_q;
    if (tx_req && en_q && start_sync_en) pend_d = 1'b1;
    if (pend_q && rx_rise)               pend_d = 1'b0;
    if (!en_d)                           pend_d = 1'b0;

    start_d = (tx_req & en_q & ~start_sync_en) | (pend_q & rx_rise & en_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  assign tx_en    = en_q;
  assign tx_start = start_q;

  // R8
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && auto_clr_en |=> !en_q);
  // R9
  direct_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && en_q && !start_sync_en |=> start_q);
  // R10
  pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !rx_rise && !tx_req |=> !start_q);
  // R11
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> en_q);
endmodule

// File: rtl/uart_bus_collision_det.sv
module uart_bus_collision_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_pin,
  input  logic txd_lvl,
  input  logic frame_act,
  input  logic xfer_clk,
  input  logic tmr_uflow,
  input  logic smp_sel,
  input  logic auto_clr_en,
  input  logic start_sync_en,
  input  logic tx_en_set,
  input  logic tx_en_clr,
  input  logic tx_req,
  input  logic irq_clr,
  output logic tx_en,
  output logic tx_start,
  output logic coll_flag,
  output logic coll_irq
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;
  logic rxd_s, rxd_rise, txd_d, act_d, strobe, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= RST_STAGES'({rst_pipe_q, 1'b1});
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  bcd_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_s_n), .rxd_pin(rxd_pin), .txd_lvl(txd_lvl),
    .frame_act(frame_act), .rxd_s(rxd_s), .rxd_rise(rxd_rise),
    .txd_d(txd_d), .act_d(act_d)
  );

  bcd_strobe_sel strobe_i (
    .clk(clk), .rst_n(rst_s_n), .xfer_clk(xfer_clk), .tmr_uflow(tmr_uflow),
    .smp_sel(smp_sel), .strobe(strobe)
  );

  bcd_coll_flag flag_i (
    .clk(clk), .rst_n(rst_s_n), .strobe(strobe), .act_d(act_d),
    .rxd_s(rxd_s), .txd_d(txd_d), .irq_clr(irq_clr), .hit(hit),
    .flag(coll_flag), .irq(coll_irq)
  );

  bcd_tx_gate gate_i (
    .clk(clk), .rst_n(rst_s_n), .hit(hit), .auto_clr_en(auto_clr_en),
    .tx_en_set(tx_en_set), .tx_en_clr(tx_en_clr), .tx_req(tx_req),
    .start_sync_en(start_sync_en), .rx_rise(rxd_rise),
    .tx_en(tx_en), .tx_start(tx_start)
  );
endmodule

// File: tb/uart_bus_collision_det_tb.sv
module uart_bus_collision_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd_pin = 0, txd_lvl = 0, frame_act = 0, xfer_clk = 0, tmr_uflow = 0;
  logic smp_sel = 0, auto_clr_en = 0, start_sync_en = 0;
  logic tx_en_set = 0, tx_en_clr = 0, tx_req = 0, irq_clr = 0;
  logic tx_en, tx_start, coll_flag, coll_irq;

  int checks = 0, fails = 0;
  int irq_tot = 0, start_tot = 0;
  bit done = 0;

  // fields {smp_sel, xfer_rise, tmr_pulse, active, rxd, txd, expect}
  localparam logic [6:0] VEC [0:7] = '{
    7'b0101011, 7'b0101110, 7'b0011010, 7'b1011011,
    7'b1101010, 7'b1010010, 7'b0100010, 7'b1011101
  };

  always #5 clk = ~clk;

  uart_bus_collision_det dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_pin(rxd_pin), .txd_lvl(txd_lvl),
    .frame_act(frame_act), .xfer_clk(xfer_clk), .tmr_uflow(tmr_uflow),
    .smp_sel(smp_sel), .auto_clr_en(auto_clr_en), .start_sync_en(start_sync_en),
    .tx_en_set(tx_en_set), .tx_en_clr(tx_en_clr), .tx_req(tx_req),
    .irq_clr(irq_clr), .tx_en(tx_en), .tx_start(tx_start),
    .coll_flag(coll_flag), .coll_irq(coll_irq)
  );

  always @(posedge clk) begin
    if (coll_irq) irq_tot++;
    if (tx_start) start_tot++;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_once(logic xs, logic ts);
    xfer_clk = xs; tmr_uflow = ts;
    tick();
    xfer_clk = 0; tmr_uflow = 0;
  endtask

  task automatic clear_flag();
    irq_clr = 1; tick(); irq_clr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int snap;
    tick(3);
    // R1
    check("R1 tx_en", tx_en, 0);
    check("R1 flag", coll_flag, 0);
    check("R1 irq", coll_irq, 0);
    check("R1 start", tx_start, 0);
    rst_n = 1;
    tick(4);
    check("R1 flag after release", coll_flag, 0);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 8; i++) begin
      smp_sel = VEC[i][6]; frame_act = VEC[i][3];
      rxd_pin = VEC[i][2]; txd_lvl = VEC[i][1];
      clear_flag();
      tick(4);
      snap = irq_tot;
      strobe_once(VEC[i][5], VEC[i][4]);
      tick(3);
      check($sformatf("R2/R3/R4/R5 vec%0d flag", i), coll_flag, VEC[i][0]);
      check($sformatf("R7 vec%0d irq count", i), irq_tot - snap, VEC[i][0]);
    end

    // R6 R7: sticky, single pulse
    smp_sel = 1; frame_act = 1; rxd_pin = 0; txd_lvl = 1;
    clear_flag(); tick(4);
    snap = irq_tot;
    strobe_once(0, 1); tick(3);
    strobe_once(0, 1); tick(10);
    check("R6 flag sticky", coll_flag, 1);
    check("R7 one pulse", irq_tot - snap, 1);
    irq_clr = 1; tmr_uflow = 1; tick();
    irq_clr = 0; tmr_uflow = 0; tick();
    check("R6 set beats clear", coll_flag, 1);
    clear_flag(); tick();
    check("R6 cleared", coll_flag, 0);

    // R8 auto clear on / off
    tx_en_set = 1; tick(); tx_en_set = 0;
    auto_clr_en = 0;
    strobe_once(0, 1); tick(2);
    check("R8 no auto clear", tx_en, 1);
    clear_flag(); auto_clr_en = 1;
    tmr_uflow = 1; tick(); tmr_uflow = 0;
    check("R8 flag set", coll_flag, 1);
    check("R8 tx_en cleared same edge", tx_en, 0);
    auto_clr_en = 0; clear_flag();
    frame_act = 0; smp_sel = 0;

    // R11 request ignored while disabled
    snap = start_tot;
    tx_req = 1; tick(); tx_req = 0; tick(3);
    check("R11 no start", start_tot - snap, 0);

    // R9 direct start
    tx_en_set = 1; tick(); tx_en_set = 0;
    tx_req = 1; tick(); tx_req = 0;
    check("R9 start next cycle", tx_start, 1);
    tick();
    check("R9 start one cycle", tx_start, 0);

    // R10 synchronized start
    rxd_pin = 0; start_sync_en = 1; tick(4);
    snap = start_tot;
    tx_req = 1; tick(); tx_req = 0; tick(10);
    check("R10 waits for edge", start_tot - snap, 0);
    rxd_pin = 1; tick(6);
    check("R10 one start after edge", start_tot - snap, 1);

    // R12 cancel pending
    rxd_pin = 0; tick(4);
    snap = start_tot;
    tx_req = 1; tick(); tx_req = 0; tick(2);
    tx_en_clr = 1; tick(); tx_en_clr = 0;
    tx_en_set = 1; tick(); tx_en_set = 0; tick(2);
    rxd_pin = 1; tick(6);
    check("R12 cancelled", start_tot - snap, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule